// File: doc/BRIEF.md
# Resolver Amplitude Degradation Monitor

This block watches a stream of unsigned magnitude words taken from the sine and cosine channels of a resolver. It reports a degraded signal through one active-low flag. Two causes drive that flag. The first is a sample that lies above a programmable over-range level. The second is a spread between the smallest and largest magnitudes seen since the last reseed that grows past a programmable mismatch limit. Demodulation and magnitude computation happen upstream of this block.

The two causes behave differently. The over-range term follows the most recent valid sample and is never latched. The mismatch term is sticky. It is released only by a rising edge of a separate sample strobe. That same edge marks the stored minimum and maximum as empty, so both bounds are loaded from the next valid sample. The running minimum and maximum are brought out as ports. All outputs are registered and change on the clock edge that takes in a valid sample, or on the edge that sees the strobe rise.

Top module: `resolver_degrade_monitor`

## Requirements
- R1: After reset, `degrade_n` is 1 and both `mag_min` and `mag_max` are 0.
- R2: On the edge that takes in a valid sample with `smp_mag` greater than `ovr_limit` as unsigned values, `degrade_n` goes to 0. A sample equal to `ovr_limit` is not over-range.
- R3: The over-range term is not latched. A later valid sample at or below `ovr_limit` returns `degrade_n` to 1 on its edge, provided no mismatch is latched.
- R4: On each valid sample, `mag_min` and `mag_max` take the smallest and largest magnitude seen since the last seed. Cycles with `smp_vld` at 0 leave both unchanged, whatever `smp_mag` holds.
- R5: On the edge that takes in a valid sample, if the updated `mag_max - mag_min` is greater than `mis_limit`, `degrade_n` goes to 0. A spread equal to `mis_limit` does not flag.
- R6: A latched mismatch holds `degrade_n` at 0 through later samples, healthy ones included, until a rising edge of `hold_strobe`. A strobe that stays high causes no further clear after its first cycle.
- R7: In the cycle where `hold_strobe` is 1 after having been 0 in the previous cycle, the mismatch latch clears on that edge. `mag_min` and `mag_max` keep their values until the next valid sample, which loads both bounds. A valid sample in the same cycle as the rising edge is itself that seed.
- R8: After reset the bounds are empty. The first valid sample loads both bounds with its value, and no mismatch can come from that sample even when `mis_limit` is 0.
- R9: `degrade_n` is 0 whenever either term is active. When over-range clears while a mismatch is latched, the output stays 0. When a mismatch clears while over-range is active, the output also stays 0.
- R10: All comparisons are unsigned. A sample of 0xFFFF is over-range against a limit of 0x7FFF, and 0x7FFF is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Marks `smp_mag` as a valid sample in this cycle |
| smp_mag | input | MAG_W | Unsigned magnitude sample |
| hold_strobe | input | 1 | Sample strobe; its rising edge clears the mismatch latch and reseeds the bounds |
| ovr_limit | input | MAG_W | Over-range level; a sample above it flags |
| mis_limit | input | MAG_W | Mismatch limit for the min/max spread |
| degrade_n | output | 1 | Degradation flag, 0 = degraded, 1 = healthy |
| mag_min | output | MAG_W | Smallest magnitude since the last seed |
| mag_max | output | MAG_W | Largest magnitude since the last seed |

## Verification
The bench builds the block with its default 16-bit magnitude. This makes the full unsigned range reachable, so samples at 0xFFFF and limits at 0x7FFF and 0xFFFF can be driven and the unsigned compare is tested at its top end. It also reaches the equality boundaries of both thresholds and a mismatch limit of 0 on a fresh seed. At this width the strobe edge can be placed on the same cycle as a sample, and the strobe can be held high across several samples.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

   localparam int RDM_MIN_W = 2;
   localparam int RDM_MAX_W = 32;
   localparam int RDM_NUM_BOUNDS = 2;

   typedef enum logic {
      BOUND_LOW  = 1'b0,
      BOUND_HIGH = 1'b1
   } bound_kind_e;

endpackage

// File: rtl/rdm_edge.sv
module rdm_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic rise
);

   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   assign rise = strobe & ~strobe_q;

   // R6: a strobe held high yields only a single rise
   p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/rdm_bound.sv
module rdm_bound #(
   parameter int                  W    = 16,
   parameter rdm_pkg::bound_kind_e KIND = rdm_pkg::BOUND_LOW
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic         seed,
   input  logic [W-1:0] mag,
   output logic [W-1:0] val,
   output logic [W-1:0] nxt
);

   logic [W-1:0] pick;

   generate
      if (KIND == rdm_pkg::BOUND_LOW) begin : g_low
         assign pick = (mag < val) ? mag : val;
      end else begin : g_high
         assign pick = (mag > val) ? mag : val;
      end
   endgenerate

   assign nxt = seed ? mag : pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val <= '0;
      else if (take) val <= nxt;
   end

   // R4: a bound only moves in its own direction unless reseeded
   generate
      if (KIND == rdm_pkg::BOUND_LOW) begin : g_chk_low
         p_low_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (take && !seed) |=> (val <= $past(val)));
      end else begin : g_chk_high
         p_high_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (take && !seed) |=> (val >= $past(val)));
      end
   endgenerate

endmodule

// File: rtl/rdm_fault.sv
module rdm_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic ovr_hit,
   input  logic mis_hit,
   input  logic clear,
   output logic degrade_n
);

   logic ovr_q;
   logic mis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ovr_q <= 1'b0;
      else if (take) ovr_q <= ovr_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mis_q <= 1'b0;
      else        mis_q <= (take & mis_hit) | (mis_q & ~clear);
   end

   assign degrade_n = ~ovr_q & ~mis_q;

   // R6: latch holds while no strobe edge arrives
   p_mis_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mis_q && !clear) |=> mis_q);

   // R7: a strobe edge with no fresh hit releases the latch
   p_mis_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !(take && mis_hit)) |=> !mis_q);

   // R3: over-range term is dropped by a healthy sample
   p_ovr_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !ovr_hit) |=> !ovr_q);

endmodule

// File: rtl/resolver_degrade_monitor.sv
module resolver_degrade_monitor #(
   parameter int MAG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [MAG_W-1:0] smp_mag,
   input  logic             hold_strobe,
   input  logic [MAG_W-1:0] ovr_limit,
   input  logic [MAG_W-1:0] mis_limit,
   output logic             degrade_n,
   output logic [MAG_W-1:0] mag_min,
   output logic [MAG_W-1:0] mag_max
);

   localparam int NB = rdm_pkg::RDM_NUM_BOUNDS;
   localparam int LO = 0;
   localparam int HI = NB - 1;

   generate
      if (MAG_W < rdm_pkg::RDM_MIN_W || MAG_W > rdm_pkg::RDM_MAX_W) begin : g_bad_width
         $error("MAG_W out of supported range");
      end
   endgenerate

   logic             rise;
   logic             empty_q;
   logic             seed;
   logic [MAG_W-1:0] bnd_val [NB];
   logic [MAG_W-1:0] bnd_nxt [NB];
   logic [MAG_W-1:0] spread_nxt;
   logic             ovr_hit;
   logic             mis_hit;

   rdm_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (hold_strobe),
      .rise   (rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       empty_q <= 1'b1;
      else if (smp_vld) empty_q <= 1'b0;
      else if (rise)    empty_q <= 1'b1;
   end

   assign seed = empty_q | rise;

   generate
      for (genvar g = 0; g < NB; g++) begin : g_bound
         localparam rdm_pkg::bound_kind_e K =
            (g == LO) ? rdm_pkg::BOUND_LOW : rdm_pkg::BOUND_HIGH;
         rdm_bound #(
            .W    (MAG_W),
            .KIND (K)
         ) u_bound (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (smp_vld),
            .seed  (seed),
            .mag   (smp_mag),
            .val   (bnd_val[g]),
            .nxt   (bnd_nxt[g])
         );
      end
   endgenerate

   assign spread_nxt = bnd_nxt[HI] - bnd_nxt[LO];
   assign mis_hit    = spread_nxt > mis_limit;
   assign ovr_hit    = smp_mag > ovr_limit;

   rdm_fault u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (smp_vld),
      .ovr_hit   (ovr_hit),
      .mis_hit   (mis_hit),
      .clear     (rise),
      .degrade_n (degrade_n)
   );

   assign mag_min = bnd_val[LO];
   assign mag_max = bnd_val[HI];

   // R2: an over-range sample pulls the flag low on its edge
   p_ovr_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && (smp_mag > ovr_limit)) |=> !degrade_n);

   // R4: idle cycles leave the bounds alone
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ($stable(mag_min) && $stable(mag_max)));

   // R4: once filled, the bounds are ordered
   p_ordered_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_q |-> (mag_min <= mag_max));

   // R5: an excessive spread pulls the flag low on its edge
   p_mis_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && mis_hit) |=> !degrade_n);

   // R8: a seeding sample loads both bounds with itself
   p_seed_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && seed) |=> (mag_min == mag_max && mag_min == $past(smp_mag)));

endmodule

// File: tb/resolver_degrade_monitor_test.sv
module resolver_degrade_monitor_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         smp_vld = 1'b0;
   logic [W-1:0] smp_mag = '0;
   logic         hold_strobe = 1'b0;
   logic [W-1:0] ovr_limit = 16'hF000;
   logic [W-1:0] mis_limit = 16'h0000;
   logic         degrade_n;
   logic [W-1:0] mag_min;
   logic [W-1:0] mag_max;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   resolver_degrade_monitor #(.MAG_W(W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_vld     (smp_vld),
      .smp_mag     (smp_mag),
      .hold_strobe (hold_strobe),
      .ovr_limit   (ovr_limit),
      .mis_limit   (mis_limit),
      .degrade_n   (degrade_n),
      .mag_min     (mag_min),
      .mag_max     (mag_max)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [W-1:0] m);
      @(negedge clk);
      smp_vld = 1'b1;
      smp_mag = m;
      @(negedge clk);
      smp_vld = 1'b0;
      smp_mag = 16'hAAAA;
   endtask

   task automatic pulse;
      @(negedge clk);
      hold_strobe = 1'b1;
      @(negedge clk);
      hold_strobe = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 degrade_n after reset", {15'd0, degrade_n}, 16'd1);
      chk("R1 mag_min after reset", mag_min, 16'h0000);
      chk("R1 mag_max after reset", mag_max, 16'h0000);
   endtask

   task automatic t_first_seed;
      mis_limit = 16'h0000;
      put(16'h1000);
      chk("R8 first sample min", mag_min, 16'h1000);
      chk("R8 first sample max", mag_max, 16'h1000);
      chk("R8 no mismatch with limit 0", {15'd0, degrade_n}, 16'd1);
      mis_limit = 16'h0100;
   endtask

   task automatic t_track;
      put(16'h1080);
      chk("R4 max rises", mag_max, 16'h1080);
      chk("R4 min kept", mag_min, 16'h1000);
      put(16'h0F80);
      chk("R4 min falls", mag_min, 16'h0F80);
      chk("R5 spread equal to limit healthy", {15'd0, degrade_n}, 16'd1);
      @(negedge clk); smp_mag = 16'h0001;
      @(negedge clk); smp_mag = 16'hFFFF;
      @(negedge clk);
      chk("R4 idle min stable", mag_min, 16'h0F80);
      chk("R4 idle max stable", mag_max, 16'h1080);
   endtask

   task automatic t_mismatch;
      put(16'h0F7F);
      chk("R5 spread above limit flags", {15'd0, degrade_n}, 16'd0);
      put(16'h1000);
      chk("R6 latched through healthy sample", {15'd0, degrade_n}, 16'd0);
      repeat (3) @(negedge clk);
      chk("R6 latched while idle", {15'd0, degrade_n}, 16'd0);
      pulse();
      chk("R7 strobe edge clears", {15'd0, degrade_n}, 16'd1);
      chk("R7 min held until sample", mag_min, 16'h0F7F);
      chk("R7 max held until sample", mag_max, 16'h1080);
      put(16'h2000);
      chk("R7 reseed min", mag_min, 16'h2000);
      chk("R7 reseed max", mag_max, 16'h2000);
   endtask

   task automatic t_held_strobe;
      put(16'h2200);
      chk("R5 second mismatch", {15'd0, degrade_n}, 16'd0);
      @(negedge clk); hold_strobe = 1'b1;
      @(negedge clk);
      chk("R7 held strobe first edge clears", {15'd0, degrade_n}, 16'd1);
      put(16'h2000);
      chk("R7 reseed under held strobe", mag_max, 16'h2000);
      put(16'h2300);
      chk("R5 mismatch under held strobe", {15'd0, degrade_n}, 16'd0);
      repeat (3) @(negedge clk);
      chk("R6 held strobe does not clear again", {15'd0, degrade_n}, 16'd0);
      hold_strobe = 1'b0;
      @(negedge clk);
      chk("R6 strobe fall does not clear", {15'd0, degrade_n}, 16'd0);
   endtask

   task automatic t_coincident;
      @(negedge clk);
      hold_strobe = 1'b1;
      smp_vld = 1'b1;
      smp_mag = 16'h3000;
      @(negedge clk);
      hold_strobe = 1'b0;
      smp_vld = 1'b0;
      chk("R7 coincident edge clears", {15'd0, degrade_n}, 16'd1);
      chk("R7 coincident sample seeds min", mag_min, 16'h3000);
      chk("R7 coincident sample seeds max", mag_max, 16'h3000);
   endtask

   task automatic t_overrange;
      mis_limit = 16'hFFFF;
      ovr_limit = 16'hF000;
      pulse();
      put(16'hF000);
      chk("R2 sample equal to limit healthy", {15'd0, degrade_n}, 16'd1);
      put(16'hF001);
      chk("R2 sample above limit flags", {15'd0, degrade_n}, 16'd0);
      put(16'h0010);
      chk("R3 over-range released", {15'd0, degrade_n}, 16'd1);
      ovr_limit = 16'h7FFF;
      put(16'hFFFF);
      chk("R10 0xFFFF above 0x7FFF", {15'd0, degrade_n}, 16'd0);
      put(16'h7FFF);
      chk("R10 0x7FFF not above 0x7FFF", {15'd0, degrade_n}, 16'd1);
      chk("R4 full range min", mag_min, 16'h0010);
      chk("R4 full range max", mag_max, 16'hFFFF);
   endtask

   task automatic t_combine;
      mis_limit = 16'h0010;
      ovr_limit = 16'h7FFF;
      pulse();
      put(16'h1000);
      chk("R9 healthy after seed", {15'd0, degrade_n}, 16'd1);
      put(16'h9000);
      chk("R9 both terms active", {15'd0, degrade_n}, 16'd0);
      put(16'h1000);
      chk("R9 mismatch alone keeps low", {15'd0, degrade_n}, 16'd0);
      pulse();
      chk("R9 all terms cleared", {15'd0, degrade_n}, 16'd1);
      put(16'h8000);
      chk("R9 over-range alone low", {15'd0, degrade_n}, 16'd0);
      pulse();
      chk("R9 strobe keeps over-range low", {15'd0, degrade_n}, 16'd0);
      put(16'h0100);
      chk("R9 healthy reseed", {15'd0, degrade_n}, 16'd1);
   endtask

   initial begin
      #2_000_000;
      n_err++;
      $display("FAIL watchdog (all R): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_seed();
      t_track();
      t_mismatch();
      t_held_strobe();
      t_coincident();
      t_overrange();
      t_combine();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule